// File: doc/BRIEF.md
# Implicit Predicate Lookup

This block decides, at instruction decode, whether a write to a destination register is masked element by element. Software fills a 16-slot configuration table. Each slot names a target register, says whether that register is in the integer or the floating-point file, and names an integer register whose bits serve as the element mask. The instruction itself never carries a predicate operand. The destination register alone selects the mask through this table.

The table is kept in two forms. The slots are held in flops. Combinational logic reshapes them into one 32-entry map per register file, keyed by register number. A decode-time query supplies a destination register, its file and an element number. The block answers three things: whether predication applies, which integer register holds the mask, and whether the element may be written. It addresses the integer register file through a read port that returns data in the same cycle, and it picks the element's bit from the returned value.

Top module: `pred_lookup`

## Requirements
- R1: After synchronous reset, all 16 slots are cleared, and every query reports `pred_active` = 0.
- R2: A slot is written when `cfg_we` = 1, at slot `cfg_idx`. The bit layout of `cfg_wdata` is: [4:0] target register, [5] file select, [6] enable, [11:7] mask register. A query that hits an enabled slot reports `pred_active` = 1, with `pred_reg` equal to that slot's mask register.
- R3: A slot whose enable bit (bit 6) is 0 has no effect on any query.
- R4: File select 0 targets the integer file and 1 targets the floating-point file. A slot matches only queries with the same `q_is_fp` value.
- R5: When several enabled slots name the same register in the same file, the slot with the highest index decides the mask register.
- R6: A table write takes effect for queries in the following cycle. While no write occurs and the query register is unchanged, the query outputs stay unchanged.
- R7: When predication applies, `rf_raddr` equals `pred_reg`, and for `q_elem` < 64, `elem_enable` equals bit `q_elem` of `rf_rdata`.
- R8: When predication does not apply, `elem_enable` is 1 for any element number.
- R9: When predication applies and `q_elem` >= 64 (XLEN), `elem_enable` is 0.
- R10: Rewriting a slot removes its earlier mapping. Queries then fall back to any remaining enabled slot that matches.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Table slot write strobe |
| cfg_idx | input | 4 | Slot number to write |
| cfg_wdata | input | 12 | Slot contents (layout in R2) |
| q_reg | input | 5 | Destination register of the query |
| q_is_fp | input | 1 | 1 = destination is in the floating-point file |
| q_elem | input | 7 | Vector element number |
| rf_raddr | output | 5 | Integer register file read address |
| rf_rdata | input | 64 | Integer register file read data, same cycle |
| pred_active | output | 1 | Destination register is predicated |
| pred_reg | output | 5 | Integer register holding the mask |
| elem_enable | output | 1 | Element may be written |

## Verification
All query results are combinational. They are due in the same cycle as the query inputs and the register file data, with zero registers on the path. A table write is due one clock later, once the slot flop has captured it. The bench drives every stimulus on the falling edge. The scoreboard monitor compares one nanosecond after the next rising edge, a point where inputs have been settled for half a period and no write is in flight. Each write is followed by at least one full cycle before the query that depends on it.

// File: rtl/pred_pkg.sv
package pred_pkg;
    localparam int NUM_SLOTS = 16;
    localparam int NUM_REGS  = 32;
    localparam int REG_W     = $clog2(NUM_REGS);
    localparam int XLEN      = 64;
    localparam int ELEM_W    = $clog2(XLEN) + 1;

    typedef enum logic {
        RF_INT = 1'b0,
        RF_FP  = 1'b1
    } rf_kind_e;

    // slot layout: [11:7] mask reg, [6] enable, [5] file, [4:0] target
    typedef struct packed {
        logic [REG_W-1:0] mask_reg;
        logic             enable;
        rf_kind_e         kind;
        logic [REG_W-1:0] target;
    } slot_t;

    localparam int SLOT_W = $bits(slot_t);

    typedef struct packed {
        logic             active;
        logic [REG_W-1:0] mask_reg;
    } map_t;

    function automatic logic pick_bit(input logic [XLEN-1:0] m,
                                      input logic [ELEM_W-1:0] i);
        if (i < ELEM_W'(XLEN))
            return m[i[ELEM_W-2:0]];
        return 1'b0;
    endfunction
endpackage

// File: rtl/pred_slots.sv
module pred_slots
    import pred_pkg::*;
#(
    parameter int N = NUM_SLOTS,
    localparam int IDX_W = $clog2(N)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             we,
    input  logic [IDX_W-1:0] widx,
    input  slot_t            wdata,
    output slot_t [N-1:0]    slots
);
    always_ff @(posedge clk) begin
        if (rst) begin
            slots <= '0;
        end else if (we) begin
            slots[widx] <= wdata;
        end
    end
endmodule

// File: rtl/pred_invert.sv
module pred_invert
    import pred_pkg::*;
#(
    parameter int       N    = NUM_SLOTS,
    parameter int       R    = NUM_REGS,
    parameter rf_kind_e KIND = RF_INT
) (
    input  slot_t [N-1:0] slots,
    output map_t  [R-1:0] map
);
    // ascending scan: later slots overwrite earlier ones
    always_comb begin
        map = '0;
        for (int s = 0; s < N; s++) begin
            if (slots[s].enable && slots[s].kind == KIND) begin
                map[slots[s].target].active   = 1'b1;
                map[slots[s].target].mask_reg = slots[s].mask_reg;
            end
        end
    end
endmodule

// File: rtl/pred_query.sv
module pred_query
    import pred_pkg::*;
#(
    parameter int R = NUM_REGS
) (
    input  map_t [R-1:0]      int_map,
    input  map_t [R-1:0]      fp_map,
    input  logic [REG_W-1:0]  q_reg,
    input  logic              q_is_fp,
    input  logic [ELEM_W-1:0] q_elem,
    input  logic [XLEN-1:0]   mask_word,
    output logic              active,
    output logic [REG_W-1:0]  mask_reg
);
    map_t hit;
    always_comb begin
        hit      = q_is_fp ? fp_map[q_reg] : int_map[q_reg];
        active   = hit.active;
        mask_reg = hit.mask_reg;
    end
endmodule

// File: rtl/pred_lookup.sv
module pred_lookup
    import pred_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 cfg_we,
    input  logic [3:0]           cfg_idx,
    input  logic [SLOT_W-1:0]    cfg_wdata,
    input  logic [REG_W-1:0]     q_reg,
    input  logic                 q_is_fp,
    input  logic [ELEM_W-1:0]    q_elem,
    output logic [REG_W-1:0]     rf_raddr,
    input  logic [XLEN-1:0]      rf_rdata,
    output logic                 pred_active,
    output logic [REG_W-1:0]     pred_reg,
    output logic                 elem_enable
);
    slot_t [NUM_SLOTS-1:0] slots;
    map_t  [NUM_REGS-1:0]  maps [2];
    logic                  act;
    logic [REG_W-1:0]      mreg;

    pred_slots #(.N(NUM_SLOTS)) u_slots (
        .clk   (clk),
        .rst   (rst),
        .we    (cfg_we),
        .widx  (cfg_idx),
        .wdata (slot_t'(cfg_wdata)),
        .slots (slots)
    );

    for (genvar k = 0; k < 2; k++) begin : g_inv
        pred_invert #(
            .N    (NUM_SLOTS),
            .R    (NUM_REGS),
            .KIND (rf_kind_e'(k))
        ) u_inv (
            .slots (slots),
            .map   (maps[k])
        );
    end

    pred_query #(.R(NUM_REGS)) u_query (
        .int_map   (maps[0]),
        .fp_map    (maps[1]),
        .q_reg     (q_reg),
        .q_is_fp   (q_is_fp),
        .q_elem    (q_elem),
        .mask_word (rf_rdata),
        .active    (act),
        .mask_reg  (mreg)
    );

    always_comb begin
        pred_active = act;
        pred_reg    = mreg;
        rf_raddr    = mreg;
        elem_enable = !act || pick_bit(rf_rdata, q_elem);
    end
endmodule

// File: rtl/pred_lookup_chk.sv
module pred_lookup_chk
    import pred_pkg::*;
(
    input logic                 clk,
    input logic                 rst,
    input logic                 cfg_we,
    input logic [REG_W-1:0]     q_reg,
    input logic                 q_is_fp,
    input logic [ELEM_W-1:0]    q_elem,
    input logic [XLEN-1:0]      rf_rdata,
    input logic                 pred_active,
    input logic [REG_W-1:0]     pred_reg,
    input logic                 elem_enable
);
    p_reset_clear_r1: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> !pred_active);

    p_hold_r6: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && !$past(cfg_we) && $stable(q_reg) && $stable(q_is_fp))
        |-> ($stable(pred_active) && $stable(pred_reg)));

    p_mask_bit_r7: assert property (@(posedge clk) disable iff (rst)
        (pred_active && q_elem < ELEM_W'(XLEN))
        |-> (elem_enable == rf_rdata[q_elem[ELEM_W-2:0]]));

    p_all_on_r8: assert property (@(posedge clk) disable iff (rst)
        !pred_active |-> elem_enable);

    p_out_range_r9: assert property (@(posedge clk) disable iff (rst)
        (pred_active && q_elem >= ELEM_W'(XLEN)) |-> !elem_enable);
endmodule

bind pred_lookup pred_lookup_chk u_chk (
    .clk         (clk),
    .rst         (rst),
    .cfg_we      (cfg_we),
    .q_reg       (q_reg),
    .q_is_fp     (q_is_fp),
    .q_elem      (q_elem),
    .rf_rdata    (rf_rdata),
    .pred_active (pred_active),
    .pred_reg    (pred_reg),
    .elem_enable (elem_enable)
);

// File: tb/sim_pred_lookup.sv
`timescale 1ns/1ps
module sim_pred_lookup;
    import pred_pkg::*;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              cfg_we = 1'b0;
    logic [3:0]        cfg_idx = '0;
    logic [11:0]       cfg_wdata = '0;
    logic [4:0]        q_reg = '0;
    logic              q_is_fp = 1'b0;
    logic [6:0]        q_elem = '0;
    logic [4:0]        rf_raddr;
    logic [63:0]       rf_rdata;
    logic              pred_active;
    logic [4:0]        pred_reg;
    logic              elem_enable;

    always #2.5 clk = ~clk;

    pred_lookup u0 (.*);

    logic [63:0] rf [32];
    assign rf_rdata = rf[rf_raddr];

    // reference table
    logic        m_en   [16];
    logic        m_fp   [16];
    logic [4:0]  m_tgt  [16];
    logic [4:0]  m_mask [16];

    typedef struct {
        logic       act;
        logic [4:0] preg;
        logic       en;
        logic [4:0] addr;
        string      req;
    } exp_t;
    exp_t sb [$];

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    task automatic wr(input int idx, input bit en, input bit fp,
                      input int tgt, input int mreg);
        @(negedge clk);
        cfg_we    = 1'b1;
        cfg_idx   = 4'(idx);
        cfg_wdata = {5'(mreg), en, fp, 5'(tgt)};
        m_en[idx] = en; m_fp[idx] = fp;
        m_tgt[idx] = 5'(tgt); m_mask[idx] = 5'(mreg);
    endtask

    task automatic query(input int r, input bit fp, input int el, input string req);
        exp_t e;
        @(negedge clk);
        cfg_we  = 1'b0;
        q_reg   = 5'(r);
        q_is_fp = fp;
        q_elem  = 7'(el);
        e.act = 1'b0; e.preg = '0;
        for (int s = 0; s < 16; s++)
            if (m_en[s] && m_fp[s] == fp && m_tgt[s] == 5'(r)) begin
                e.act = 1'b1; e.preg = m_mask[s];
            end
        if (!e.act) e.en = 1'b1;
        else if (el >= 64) e.en = 1'b0;
        else e.en = rf[e.preg][el];
        e.addr = e.preg;
        e.req  = req;
        sb.push_back(e);
    endtask

    // monitor
    initial begin
        forever begin
            @(posedge clk);
            #1;
            if (sb.size() > 0) begin
                exp_t e;
                e = sb.pop_front();
                checks++;
                if (pred_active !== e.act || elem_enable !== e.en ||
                    (e.act && (pred_reg !== e.preg || rf_raddr !== e.addr))) begin
                    fails++;
                    $display("FAIL %s: act/reg/en/addr got %b/%0d/%b/%0d expected %b/%0d/%b/%0d",
                             e.req, pred_active, pred_reg, elem_enable, rf_raddr,
                             e.act, e.preg, e.en, e.addr);
                end
            end
        end
    end

    initial begin
        #100000;
        if (!done) begin
            fails++;
            $display("FAIL watchdog: got hang expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    end

    initial begin
        for (int r = 0; r < 32; r++)
            rf[r] = (64'h9E3779B97F4A7C15 * 64'(r + 1)) ^ {32'(r), 32'hC3A50F69};
        for (int s = 0; s < 16; s++) begin
            m_en[s] = 0; m_fp[s] = 0; m_tgt[s] = '0; m_mask[s] = '0;
        end
        repeat (3) @(posedge clk);
        @(negedge clk) rst = 1'b0;

        // R1, R8: nothing predicated after reset
        query(3, 0, 0, "R1");
        query(3, 1, 5, "R1");
        query(31, 0, 70, "R8");

        // R2, R6, R7: integer mapping
        wr(0, 1, 0, 4, 9);
        query(4, 0, 0, "R6");
        for (int el = 0; el < 64; el += 7) query(4, 0, el, "R7");
        query(4, 0, 63, "R2");

        // R4: file separation
        query(4, 1, 3, "R4");
        wr(1, 1, 1, 4, 12);
        query(4, 1, 3, "R4");
        query(4, 0, 3, "R4");

        // R5: highest slot wins
        wr(5, 1, 0, 4, 17);
        query(4, 0, 11, "R5");
        wr(2, 1, 0, 4, 20);
        query(4, 0, 11, "R5");

        // R3: disabled slot ignored
        wr(7, 0, 0, 10, 3);
        query(10, 0, 2, "R3");
        wr(8, 0, 1, 4, 25);
        query(4, 1, 6, "R3");

        // R10: rewriting slot 5 falls back to slot 2
        wr(5, 0, 0, 4, 17);
        query(4, 0, 11, "R10");
        wr(2, 1, 0, 6, 20);
        query(4, 0, 11, "R10");

        // R9: out-of-range element
        query(6, 0, 64, "R9");
        query(6, 0, 127, "R9");
        query(6, 0, 31, "R7");

        // R2: every slot, distinct targets in both files
        for (int s = 0; s < 16; s++) wr(s, 1, s % 2, s + 8, 31 - s);
        for (int s = 0; s < 16; s++) query(s + 8, s % 2, s * 4, "R2");
        for (int s = 0; s < 16; s++) query(s + 8, (s + 1) % 2, s, "R4");

        @(negedge clk);
        @(negedge clk);
        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end
endmodule